// File: doc/BRIEF.md
# Parallel Bus Memory Card Controller

This block is the controller of a memory card that sits on an eight-bit parallel bus with a sixteen-bit address. It holds a byte array, 4 KB by default, and answers only to addresses inside one aligned window whose base is a parameter. During a memory read it drives the byte at the addressed location onto the bus, but only while the CPU qualifies the cycle with its data-bus-in strobe. It stores the bus byte when the memory write strobe is active.

Each 256-byte page of the card can be write protected. Protect and unprotect requests act on the page under the current address. Writes to a protected page are dropped, and the card raises a protection status line whenever a protected page is addressed. A parameter can make every access hold the ready line low for a fixed number of clocks, which stretches the cycle.

The bus data lines are given as separate output, output-enable and input ports, so the chip-level pad ring builds the tri-state driver. Reset clears the protection state and leaves the stored bytes as they are.

Top module: `memcard_ctrl`

## Requirements
- R1: The card is selected only when `addr` lies in [BASE_ADDR, BASE_ADDR + MEM_BYTES). For any other address, `data_oe` and `prot_out` stay 0, `rdy_out` stays 1, and no byte or protection bit changes. BASE_ADDR must be a multiple of MEM_BYTES and of 4096.
- R2: `data_oe` is 1 exactly while the card is selected, `io_cycle` is 0, and both `mem_rd` and `dbin` are 1. While `data_oe` is 1, `data_out` carries the byte stored at offset `addr - BASE_ADDR`.
- R3: A byte is stored at a rising clock edge when the card is selected, `io_cycle` is 0, `mwr` is 1, `rdy_out` is 1 and the addressed page is unprotected. The stored value is `data_in` and the offset is `addr - BASE_ADDR`.
- R4: The page index is `(addr - BASE_ADDR) / 256`. At a clock edge where the card is selected and `io_cycle` is 0, `prot_req` sets that page's protection bit and `unprot_req` clears it. If both are 1, the bit is set. The new state is visible from the next cycle.
- R5: A write strobe aimed at a protected page leaves the stored byte unchanged.
- R6: `prot_out` is 1 in the same cycle whenever the card is selected, `io_cycle` is 0 and the addressed page is protected. It does not depend on any strobe.
- R7: An access is a selected, non-I/O cycle with `mem_rd` or `mwr` at 1. `rdy_out` is 0 during the first WAIT_CLKS consecutive cycles of an access and 1 at every other time. With the default WAIT_CLKS of 0, `rdy_out` is always 1.
- R8: While `rst_n` is 0, every protection bit is cleared. The stored bytes are not changed by reset.
- R9: While `io_cycle` is 1, the card does not drive the bus, reports no protection, stores nothing and ignores protect and unprotect requests.
- R10: When a write commits and a protect request for the same page fall in the same cycle, the write is judged against the protection state from before that edge, so the byte is stored and the page becomes protected afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Data lines as seen by the card |
| data_out | output | DATA_W | Read data to the pad driver (0 when not driving) |
| data_oe | output | 1 | Output enable for the data line driver |
| mem_rd | input | 1 | Memory read status |
| dbin | input | 1 | Data-bus-in strobe |
| mwr | input | 1 | Memory write strobe |
| io_cycle | input | 1 | The current cycle is an I/O cycle |
| prot_req | input | 1 | Protect the addressed page |
| unprot_req | input | 1 | Unprotect the addressed page |
| prot_out | output | 1 | The addressed page is protected |
| rdy_out | output | 1 | Memory ready, 0 while stretching an access |

## Verification
A write commit and a protect request for the same page can land in one cycle. This is only interesting when the write has gone through its wait states, because the commit happens at the edge where ready returns. The bench raises the protect request in exactly that final ready cycle of a write. It checks that the byte reads back stored and that the protection line is up afterwards. It then repeats the scenario with the request placed in the first wait cycle, where the write must now be dropped. A reference model that keeps per-page protection and a wait counter of its own judges every cycle of both scenarios.

// File: rtl/memcard_pkg.sv
package memcard_pkg;

   // operation applied to the protection bit of the addressed page
   typedef enum logic [1:0] {
      PG_HOLD = 2'd0,
      PG_SET  = 2'd1,
      PG_CLR  = 2'd2
   } pg_op_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/memcard_decode.sv
module memcard_decode #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned MEM_BYTES  = 4096,
   parameter int unsigned PAGE_BYTES = 256,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   localparam int unsigned OFFS_W = $clog2(MEM_BYTES),
   localparam int unsigned PGO_W  = $clog2(PAGE_BYTES),
   localparam int unsigned PAGE_W = OFFS_W - PGO_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              io_cycle,
   output logic              sel,
   output logic [OFFS_W-1:0] offset,
   output logic [PAGE_W-1:0] page
);
   localparam int unsigned TAG_W = ADDR_W - OFFS_W;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:OFFS_W];

   logic in_win;

   always_comb begin
      in_win = (addr[ADDR_W-1:OFFS_W] == BASE_TAG);
      sel    = in_win && !io_cycle;
      offset = addr[OFFS_W-1:0];
      page   = addr[OFFS_W-1:PGO_W];
   end

endmodule

// File: rtl/memcard_protect.sv
module memcard_protect
   import memcard_pkg::*;
#(
   parameter int unsigned NUM_PAGES = 16,
   localparam int unsigned PAGE_W = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [PAGE_W-1:0] page,
   input  logic              prot_req,
   input  logic              unprot_req,
   output logic              page_prot
);
   logic [NUM_PAGES-1:0] prot_q;
   pg_op_e               op;

   always_comb begin
      op = PG_HOLD;
      if (sel && prot_req)        op = PG_SET;   // protect wins over unprotect
      else if (sel && unprot_req) op = PG_CLR;
      page_prot = prot_q[page];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= '0;
      end else begin
         case (op)
            PG_SET:  prot_q[page] <= 1'b1;
            PG_CLR:  prot_q[page] <= 1'b0;
            default: prot_q       <= prot_q;
         endcase
      end
   end

endmodule

// File: rtl/memcard_waitgen.sv
module memcard_waitgen #(
   parameter int unsigned WAIT_CLKS = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic access,
   output logic rdy
);
   generate
      if (WAIT_CLKS == 0) begin : g_nowait
         assign rdy = 1'b1;
      end else begin : g_wait
         localparam int unsigned CW = $clog2(WAIT_CLKS + 1);
         localparam logic [CW-1:0] LIMIT = CW'(WAIT_CLKS);
         logic [CW-1:0] cnt_q;

         assign rdy = !access || (cnt_q == LIMIT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!access)        cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/memcard_array.sv
module memcard_array #(
   parameter int unsigned DEPTH  = 4096,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/memcard_ctrl.sv
module memcard_ctrl
   import memcard_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MEM_BYTES  = 4096,
   parameter int unsigned PAGE_BYTES = 256,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int unsigned WAIT_CLKS  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   input  logic              mem_rd,
   input  logic              dbin,
   input  logic              mwr,
   input  logic              io_cycle,
   input  logic              prot_req,
   input  logic              unprot_req,
   output logic              prot_out,
   output logic              rdy_out
);
   localparam int unsigned OFFS_W    = $clog2(MEM_BYTES);
   localparam int unsigned NUM_PAGES = MEM_BYTES / PAGE_BYTES;
   localparam int unsigned PAGE_W    = $clog2(NUM_PAGES);

   // elaboration-time parameter checks
   generate
      if (!is_pow2(MEM_BYTES) || MEM_BYTES < 4096 || OFFS_W >= ADDR_W) begin : g_bad_size
         $error("memcard_ctrl: MEM_BYTES must be a power of two, at least 4096 and below the address space");
      end
      if (!is_pow2(PAGE_BYTES) || PAGE_BYTES * 2 > MEM_BYTES) begin : g_bad_page
         $error("memcard_ctrl: PAGE_BYTES must be a power of two at most half of MEM_BYTES");
      end
      if ((BASE_ADDR % MEM_BYTES) != 0 || (BASE_ADDR % 4096) != 0) begin : g_bad_base
         $error("memcard_ctrl: BASE_ADDR must be aligned to MEM_BYTES and to 4096");
      end
   endgenerate

   logic              sel;
   logic [OFFS_W-1:0] offset;
   logic [PAGE_W-1:0] page;
   logic              page_prot;
   logic              access;
   logic              rdy;
   logic              we;
   logic [DATA_W-1:0] rdata;

   memcard_decode #(
      .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES),
      .PAGE_BYTES(PAGE_BYTES), .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .addr(addr), .io_cycle(io_cycle),
      .sel(sel), .offset(offset), .page(page)
   );

   memcard_protect #(.NUM_PAGES(NUM_PAGES)) u_protect (
      .clk(clk), .rst_n(rst_n), .sel(sel), .page(page),
      .prot_req(prot_req), .unprot_req(unprot_req),
      .page_prot(page_prot)
   );

   memcard_waitgen #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
      .clk(clk), .rst_n(rst_n), .access(access), .rdy(rdy)
   );

   memcard_array #(.DEPTH(MEM_BYTES), .DATA_W(DATA_W)) u_array (
      .clk(clk), .we(we), .waddr(offset), .wdata(data_in),
      .raddr(offset), .rdata(rdata)
   );

   always_comb begin
      access   = sel && (mem_rd || mwr);
      we       = sel && mwr && rdy && !page_prot;
      data_oe  = sel && mem_rd && dbin;
      data_out = data_oe ? rdata : '0;
      prot_out = sel && page_prot;
      rdy_out  = rdy;
   end

endmodule

// File: rtl/memcard_ctrl_checker.sv
module memcard_ctrl_checker #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MEM_BYTES = 4096,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              data_oe,
   input logic              mem_rd,
   input logic              dbin,
   input logic              mwr,
   input logic              io_cycle,
   input logic              prot_req,
   input logic              prot_out,
   input logic              rdy_out
);
   localparam int unsigned OFFS_W = $clog2(MEM_BYTES);

   logic in_win;
   logic was_rst = 1'b0;

   assign in_win = (addr[ADDR_W-1:OFFS_W] == BASE_ADDR[ADDR_W-1:OFFS_W]);

   always_ff @(posedge clk) was_rst <= !rst_n;

   a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (!data_oe && !prot_out && rdy_out));

   a_r2_drive_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (mem_rd && dbin && !io_cycle));

   a_r4_protect_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !io_cycle && prot_req) |=> (!$stable(addr) || io_cycle || prot_out));

   a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd || mwr) |-> rdy_out);

   a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      was_rst |-> !prot_out);

   a_r9_io_silent: assert property (@(posedge clk) disable iff (!rst_n)
      io_cycle |-> (!data_oe && !prot_out && rdy_out));

endmodule

bind memcard_ctrl memcard_ctrl_checker #(
   .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .data_oe(data_oe),
   .mem_rd(mem_rd), .dbin(dbin), .mwr(mwr), .io_cycle(io_cycle),
   .prot_req(prot_req), .prot_out(prot_out), .rdy_out(rdy_out)
);

// File: tb/memcard_ctrl_tb.sv
`timescale 1ns/1ps
module memcard_ctrl_tb_top;
   localparam int W    = 2;
   localparam int BASE = 'h2000;
   localparam int SIZE = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  data_in = '0;
   logic [7:0]  data_out;
   logic        data_oe;
   logic        mem_rd = 0, dbin = 0, mwr = 0, io_cycle = 0;
   logic        prot_req = 0, unprot_req = 0;
   logic        prot_out, rdy_out;
   wire  [7:0]  bus = data_oe ? data_out : 8'hzz;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   memcard_ctrl #(.BASE_ADDR(16'h2000), .WAIT_CLKS(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .mem_rd(mem_rd), .dbin(dbin),
      .mwr(mwr), .io_cycle(io_cycle), .prot_req(prot_req),
      .unprot_req(unprot_req), .prot_out(prot_out), .rdy_out(rdy_out)
   );

   // ---------------- behavioural reference model ----------------
   byte unsigned mem_m [int];
   bit   prot_m [16];
   int   cnt_m = 0;

   function automatic bit m_sel();
      return (int'(addr) >= BASE) && (int'(addr) < BASE + SIZE) && !io_cycle;
   endfunction
   function automatic int m_page();
      return (int'(addr) - BASE) / 256;
   endfunction
   function automatic bit m_acc();
      return m_sel() && (mem_rd || mwr);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (prot_m[i]) prot_m[i] = 0;
         cnt_m = 0;
      end else begin
         bit s, a, r;
         s = m_sel();
         a = m_acc();
         r = !a || (cnt_m >= W);
         if (s && mwr && r && !prot_m[m_page()]) mem_m[int'(addr) - BASE] = data_in;
         if (s && prot_req) prot_m[m_page()] = 1;
         else if (s && unprot_req) prot_m[m_page()] = 0;
         if (!a) cnt_m = 0;
         else if (cnt_m < W) cnt_m = cnt_m + 1;
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (addr %h, t=%0t)", tag, act, exp, addr, $time);
      end
   endtask

   // every-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit s, eo;
         s  = m_sel();
         eo = s && mem_rd && dbin;
         check("R2 data_oe", int'(data_oe), int'(eo));
         if (eo && mem_m.exists(int'(addr) - BASE))
            check("R2 data_out", int'(bus), int'(mem_m[int'(addr) - BASE]));
         check("R6 prot_out", int'(prot_out), int'(s && prot_m[m_page()]));
         check("R7 rdy_out", int'(rdy_out), int'(!m_acc() || cnt_m >= W));
      end
   end

   // ---------------- stimulus tasks (start just after a rising edge) ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      mem_rd = 0; dbin = 0; mwr = 0; io_cycle = 0; prot_req = 0; unprot_req = 0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      addr = a; data_in = d; mwr = 1;
      repeat (W + 1) step();
      idle(); step();
   endtask

   task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
      addr = a; mem_rd = 1; dbin = 1;
      repeat (W) step();
      @(negedge clk);
      check(tag, int'(data_oe), 1);
      check(tag, int'(bus), int'(exp));
      step();
      idle(); step();
   endtask

   task automatic prot_at(input logic [15:0] a, input bit p, input bit u);
      addr = a; prot_req = p; unprot_req = u;
      step();
      idle(); step();
   endtask

   task automatic prot_look(input logic [15:0] a, input bit exp, input string tag);
      addr = a;
      @(negedge clk);
      check(tag, int'(prot_out), int'(exp));
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset oe", int'(data_oe), 0);
      check("R8 reset prot", int'(prot_out), 0);
      check("R7 reset rdy", int'(rdy_out), 1);
      rst_n = 1;
      step(); step();

      // R3: writes across the window, read back
      wr(16'h2000, 8'hA5); wr(16'h2001, 8'h3C); wr(16'h20FF, 8'h77); wr(16'h2FFF, 8'hE1);
      rd_chk(16'h2000, 8'hA5, "R3 rd 2000");
      rd_chk(16'h20FF, 8'h77, "R3 rd 20FF");
      rd_chk(16'h2FFF, 8'hE1, "R3 rd 2FFF");

      // R7: ready held low for W cycles of an access
      addr = 16'h2001; mem_rd = 1; dbin = 1;
      @(negedge clk); check("R7 first wait", int'(rdy_out), 0);
      step(); step();
      @(negedge clk); check("R7 ready after wait", int'(rdy_out), 1);
      step(); idle(); step();

      // R1: aliasing offsets outside the window change nothing
      wr(16'h3000, 8'h11); wr(16'h1001, 8'h22);
      rd_chk(16'h2000, 8'hA5, "R1 no alias 3000");
      rd_chk(16'h2001, 8'h3C, "R1 no alias 1001");
      addr = 16'h3000; mem_rd = 1; dbin = 1;
      @(negedge clk); check("R1 outside no drive", int'(data_oe), 0);
      check("R1 outside ready", int'(rdy_out), 1);
      step(); idle(); step();

      // R2: read status without data-bus-in leaves bus undriven
      addr = 16'h2000; mem_rd = 1;
      repeat (W + 1) step();
      @(negedge clk); check("R2 no dbin no drive", int'(data_oe), 0);
      step(); idle(); step();

      // R9: I/O cycles are ignored
      io_cycle = 1; addr = 16'h2000; data_in = 8'h99; mwr = 1; prot_req = 1;
      repeat (W + 1) step();
      mwr = 0; prot_req = 0; mem_rd = 1; dbin = 1;
      @(negedge clk); check("R9 io no drive", int'(data_oe), 0);
      step(); idle(); step();
      rd_chk(16'h2000, 8'hA5, "R9 io write ignored");
      prot_look(16'h2000, 0, "R9 io protect ignored");

      // R4/R6/R5: protection per page
      prot_at(16'h2010, 1, 0);
      prot_look(16'h2050, 1, "R4 page protected");
      prot_look(16'h2100, 0, "R4 neighbour page clear");
      wr(16'h2000, 8'h55);
      rd_chk(16'h2000, 8'hA5, "R5 protected write dropped");
      wr(16'h2100, 8'h66);
      rd_chk(16'h2100, 8'h66, "R5 other page writable");
      prot_at(16'h2100, 1, 1);
      prot_look(16'h21FF, 1, "R4 protect wins");
      prot_at(16'h20AA, 0, 1);
      prot_look(16'h2000, 0, "R4 unprotected");
      wr(16'h2000, 8'h5A);
      rd_chk(16'h2000, 8'h5A, "R4 write after unprotect");

      // R10: protect in the committing cycle of a write
      addr = 16'h2200; data_in = 8'h12; mwr = 1;
      repeat (W) step();
      prot_req = 1; step();
      idle(); step();
      rd_chk(16'h2200, 8'h12, "R10 write wins same cycle");
      prot_look(16'h2200, 1, "R10 page now protected");
      // protect during the first wait cycle blocks the write
      wr(16'h2300, 8'hAA);
      addr = 16'h2300; data_in = 8'h34; mwr = 1; prot_req = 1;
      step(); prot_req = 0;
      repeat (W) step();
      idle(); step();
      rd_chk(16'h2300, 8'hAA, "R10 early protect blocks write");

      // R8: reset clears protection, keeps contents
      rst_n = 0; step(); step(); rst_n = 1; step();
      prot_look(16'h2200, 0, "R8 protection cleared");
      prot_look(16'h2000, 0, "R8 page 20 cleared");
      rd_chk(16'h2001, 8'h3C, "R8 contents kept");
      rd_chk(16'h2200, 8'h12, "R8 contents kept 2200");

      step();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule